// File: doc/BRIEF.md
# Write-Once-Armed Watchdog Reset Timer

This block is a countdown watchdog that guards a processor subsystem against stalled software. It wakes up inert: after the external reset it neither counts nor can request a reset. Software arms it by writing a nonzero timeout, a count of clock cycles. That first value is latched and becomes the only timeout the watchdog will use until it is disarmed again. Each later write, whatever its data, is a kick that restarts the countdown from the latched value.

If software stops kicking and the count runs out, the block raises a reset request for a fixed number of clocks and sets a sticky cause bit in its status word. The block then disarms itself. The cause bit is not cleared by that request, so software that restarts after a watchdog reset can tell it apart from an external reset. Software clears the bit by writing zero while the block is disarmed. That write does not arm the block. Only the external reset input clears everything at once.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `status` is all zero and `sys_rst_req` is 0.
- R2: While disarmed (status bit 0 clear), the block never raises `sys_rst_req`, however many cycles pass.
- R3: A nonzero write while disarmed latches the data as the timeout N and sets status bit 0 (armed). `sys_rst_req` is first seen high after the Nth rising edge that follows the write edge.
- R4: A write while armed reloads the count with the latched N, whatever data it carries, including zero. The next request then comes N edges after that write edge.
- R5: On expiry `sys_rst_req` stays high for exactly PULSE_LEN cycles. Status bit 0 is clear from the first cycle of the pulse onward.
- R6: Expiry sets status bit 1 (timeout cause). The bit stays set through and after the pulse.
- R7: Writing zero while disarmed and not pulsing clears status bit 1 and leaves the block disarmed.
- R8: A write that lands on the same edge on which the count would expire wins. No request is raised, and the count restarts from N.
- R9: Taking `rst_n` low clears status bit 1, disarms the block and drops any request.
- R10: Writes made while the request pulse is active are ignored. The pulse length is unchanged and the block is disarmed afterwards.
- R11: After a timeout, the next nonzero write latches its own data as the new timeout.
- R12: Status bits above bit 1 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the timeout counts its rising edges |
| rst_n | input | 1 | Power-on / external reset, active low, synchronous |
| wr_en | input | 1 | One-cycle write strobe for the timeout register |
| wr_data | input | CNT_W | Data for the write (16 bits by default) |
| status | output | STAT_W | Bit 0 armed, bit 1 timeout cause, other bits zero |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The properties assume that `rst_n` is held low over the first edges and that `wr_en` and `wr_data` are always driven to known values. A write is taken as a single-cycle strobe sampled on the rising edge. The stimulus changes inputs only a fixed delay after an edge and drops `wr_en` before the next one. It re-enters reset between table rows, so every row starts from the disarmed, cause-clear state that the properties and expected delays depend on.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4,
  parameter int STAT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [STAT_W-1:0] status,
  output logic              sys_rst_req
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] tmo_q, cnt_q;
  logic             armed_q, cause_q, req_q;
  logic [PW-1:0]    pls_q;

  wire idle     = !armed_q && !req_q;
  wire first_wr = wr_en && idle && (wr_data != '0);
  wire clr_wr   = wr_en && idle && (wr_data == '0);
  wire kick     = wr_en && armed_q;
  wire expire   = armed_q && !wr_en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      cause_q <= 1'b0;
      req_q   <= 1'b0;
      pls_q   <= '0;
    end else begin
      if (first_wr) begin
        tmo_q   <= wr_data;
        cnt_q   <= wr_data;
        armed_q <= 1'b1;
      end else if (kick) begin
        cnt_q <= tmo_q;
      end else if (expire) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        cause_q <= 1'b1;
        req_q   <= 1'b1;
        pls_q   <= PW'(PULSE_LEN - 1);
      end else if (armed_q) begin
        cnt_q <= cnt_q - 1'b1;
      end

      if (clr_wr)
        cause_q <= 1'b0;

      if (req_q) begin
        if (pls_q == '0) req_q <= 1'b0;
        else             pls_q <= pls_q - 1'b1;
      end
    end
  end

  assign status      = STAT_W'({cause_q, armed_q});
  assign sys_rst_req = req_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4,
  parameter int STAT_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CNT_W-1:0]  wr_data,
  input logic [STAT_W-1:0] status,
  input logic              sys_rst_req
);

  logic [31:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)           run_len <= '0;
    else if (sys_rst_req) run_len <= run_len + 1;
    else                  run_len <= '0;
  end

  wire zero_clr = wr_en && (wr_data == '0) && !status[0] && !sys_rst_req;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && !sys_rst_req) |=> !sys_rst_req);

  p_kick_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && status[0]) |=> (status[0] && !sys_rst_req));

  p_pulse_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (run_len < PULSE_LEN));

  p_pulse_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> ($past(run_len) == PULSE_LEN - 1));

  p_pulse_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !status[0]);

  p_cause_on_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> status[1]);

  p_cause_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !zero_clr) |=> status[1]);

  p_zero_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_clr |=> (status[1:0] == 2'b00));

  p_arm_on_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data != '0) && !status[0] && !sys_rst_req) |=> status[0]);

endmodule

bind wdog_timer wdog_timer_chk #(
  .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .status(status), .sys_rst_req(sys_rst_req)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PULSE_LEN  = 4;
  localparam int STAT_W     = 8;
  localparam int NVEC       = 6;
  localparam int TMO_TAB [NVEC] = '{1, 2, 5, 16, 100, 300};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [STAT_W-1:0] status;
  logic             sys_rst_req;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .STAT_W(STAT_W)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int d);
    wr_en = 1'b1; wr_data = CNT_W'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_req(output int k);
    k = -1;
    for (int i = 1; i <= 70000; i++) begin
      tick(1);
      if (sys_rst_req) begin k = i; break; end
    end
  endtask

  task automatic pulse_len(output int l);
    l = 1;
    for (int i = 0; i < 64; i++) begin
      tick(1);
      if (!sys_rst_req) break;
      l++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, l, seen;
    tick(1);
    chk("R1 status in reset", int'(status), 0);
    chk("R1 req in reset", int'(sys_rst_req), 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 status after reset", int'(status), 0);

    seen = 0;
    for (int i = 0; i < 300; i++) begin tick(1); if (sys_rst_req) seen++; end
    chk("R2 no request while disarmed", seen, 0);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      wr(TMO_TAB[v]);
      chk("R3 armed after first write", int'(status), 1);
      wait_req(k);
      chk("R3 delay to request", k, TMO_TAB[v]);
      chk("R5 disarmed in pulse", int'(status[0]), 0);
      pulse_len(l);
      chk("R5 pulse length", l, PULSE_LEN);
      chk("R6 cause kept after pulse R12", int'(status), 2);
    end

    do_reset();
    wr(12); tick(5); wr(3);
    wait_req(k);
    chk("R4 kick data ignored", k, 12);
    pulse_len(l);

    do_reset();
    wr(8); tick(4); wr(0);
    chk("R4 zero kick keeps armed", int'(status), 1);
    wait_req(k);
    chk("R4 zero kick reloads", k, 8);
    pulse_len(l);

    do_reset();
    wr(5); tick(4); wr(9);
    chk("R8 no request on tie", int'(sys_rst_req), 0);
    chk("R8 still armed", int'(status), 1);
    wait_req(k);
    chk("R8 reload from latched", k, 5);

    wr(7);
    l = 1 + (sys_rst_req ? 1 : 0);
    if (sys_rst_req) begin
      for (int i = 0; i < 64; i++) begin tick(1); if (!sys_rst_req) break; l++; end
    end
    chk("R10 pulse length with write", l, PULSE_LEN);
    chk("R10 disarmed after pulse", int'(status), 2);

    wr(0);
    chk("R7 zero clears cause", int'(status), 0);
    seen = 0;
    for (int i = 0; i < 50; i++) begin tick(1); if (sys_rst_req) seen++; end
    chk("R7 stays disarmed", seen, 0);

    wr(6);
    wait_req(k);
    chk("R11 new timeout latched", k, 6);
    pulse_len(l);
    chk("R6 cause set", int'(status[1]), 1);

    rst_n = 1'b0; tick(2);
    chk("R9 reset clears cause", int'(status), 0);
    rst_n = 1'b1; tick(1);
    chk("R9 no request after reset", int'(sys_rst_req), 0);
    chk("R12 upper status bits", int'(status[STAT_W-1:2]), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule